// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a small multicycle processor. It steps the shared datapath through the phases of an instruction: fetch, decode, then execute, memory access and register write-back as the instruction needs them. Each phase takes one clock cycle. In every cycle the block drives the full set of datapath control lines: program-counter update, memory select, memory read and write, instruction-register load, register-file destination and write, ALU operand selection, ALU operation and next-PC source.

The 4-bit opcode comes from the instruction register. The sequencer has ten states. The control lines depend only on the current state, with one exception. In the register-operation execute step, the ALU operation is the low three opcode bits passed straight through. The block supports word loads, word stores, register-to-register ALU operations, branch-on-equal and unconditional jump.

Opcode encoding:
- Register operations: 0000–0111.
- Load: 1000.
- Store: 1001.
- Branch: 1010.
- Jump: 1011.
- Opcodes 1100–1111 are not recognised.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A synchronous active-high reset puts the sequencer in the fetch step. After any reset cycle, the next sampled outputs are the fetch outputs, even if the reset came mid-instruction.
- R2: In the fetch step, the following are 1: pc_wr, mem_rd, ir_wr. In the same step, alu_src_b=01 and pc_src=00, i_or_d=0, alu_src_a=0 and alu_op=000 (add). The next step is always decode.
- R3: In the decode step, alu_src_b=10 and alu_src_a=0, alu_op=000. The next step depends on the opcode: loads and stores go to address compute, register operations (0xxx) go to execute, 1010 goes to branch and 1011 goes to jump.
- R4: In the address-compute step, alu_src_a=1, alu_src_b=10 and alu_op=000. The next step is memory read for a load, or memory write for a store (opcode 1001).
- R5: In the load-read step, i_or_d=1 and mem_rd=1. It is followed by load write-back, where reg_wr=1, mem_to_reg=1 and reg_dst=0. The sequencer then returns to fetch.
- R6: In the store step, i_or_d=1 and mem_wr=1. The sequencer then returns to fetch.
- R7: In the execute step, alu_src_a=1, alu_src_b=00 and alu_op equals opcode bits 2..0. It is followed by register write-back, where reg_dst=1, reg_wr=1 and mem_to_reg=0. The sequencer then returns to fetch.
- R8: In the branch step, alu_src_a=1, alu_src_b=00, alu_op=011 (subtract), pc_wr_cond=1 and pc_src=01. The sequencer then returns to fetch.
- R9: In the jump step, pc_wr=1 and pc_src=10. The sequencer then returns to fetch.
- R10: In every step, each control line not listed for that step is 0. mem_rd and mem_wr are never 1 together, and neither are pc_wr and pc_wr_cond.
- R11: An opcode in the range 11xx, seen during decode, sends the sequencer straight back to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 4 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when the ALU result is zero |
| i_or_d | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| mem_to_reg | output | 1 | Register write data: 0 = ALU result, 1 = memory data |
| ir_wr | output | 1 | Instruction register load |
| reg_dst | output | 1 | Destination register select: 0 = rt field, 1 = rd field |
| reg_wr | output | 1 | Register file write |
| alu_src_a | output | 1 | ALU A input: 0 = PC, 1 = register A |
| alu_src_b | output | 2 | ALU B input: 00 = reg B, 01 = constant 1, 10 = sign-extended immediate |
| pc_src | output | 2 | Next PC: 00 = ALU, 01 = ALU result register, 10 = jump target |
| alu_op | output | 3 | ALU operation code |

## Verification
The bench builds the block with its default parameters: add code 000 and subtract code 011. With these, every step has a single fixed control word, so each cycle can be compared against a full 17-bit expected vector. All sixteen opcodes are driven through the decode dispatch: all eight register-operation codes, the four memory and flow-control codes, and the four unrecognised codes. A reset applied partway through a load also checks the recovery path into fetch.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPC_W   = 4;
    localparam int ALUOP_W = 3;
    localparam int SEL_W   = 2;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        S_FETCH   = 4'd0,
        S_DECODE  = 4'd1,
        S_ADDR    = 4'd2,
        S_LOAD_RD = 4'd3,
        S_LOAD_WB = 4'd4,
        S_STORE   = 4'd5,
        S_EXEC    = 4'd6,
        S_RWB     = 4'd7,
        S_BRANCH  = 4'd8,
        S_JUMP    = 4'd9
    } state_e;

    typedef enum logic [2:0] {
        CL_RTYPE,
        CL_LOAD,
        CL_STORE,
        CL_BRANCH,
        CL_JUMP,
        CL_BAD
    } op_class_e;

    localparam logic [SEL_W-1:0] SRCB_REG  = 2'b00;
    localparam logic [SEL_W-1:0] SRCB_ONE  = 2'b01;
    localparam logic [SEL_W-1:0] SRCB_IMM  = 2'b10;
    localparam logic [SEL_W-1:0] PCS_ALU   = 2'b00;
    localparam logic [SEL_W-1:0] PCS_OUT   = 2'b01;
    localparam logic [SEL_W-1:0] PCS_JUMP  = 2'b10;

    typedef struct packed {
        logic               pc_wr;
        logic               pc_wr_cond;
        logic               i_or_d;
        logic               mem_rd;
        logic               mem_wr;
        logic               mem_to_reg;
        logic               ir_wr;
        logic               reg_dst;
        logic               reg_wr;
        logic               alu_src_a;
        logic [SEL_W-1:0]   alu_src_b;
        logic [SEL_W-1:0]   pc_src;
        logic [ALUOP_W-1:0] alu_op;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '0;

    function automatic op_class_e classify(input logic [OPC_W-1:0] op);
        if (!op[OPC_W-1]) begin
            return CL_RTYPE;
        end
        unique case (op[OPC_W-2:0])
            3'b000:  return CL_LOAD;
            3'b001:  return CL_STORE;
            3'b010:  return CL_BRANCH;
            3'b011:  return CL_JUMP;
            default: return CL_BAD;
        endcase
    endfunction

endpackage

// File: rtl/mc_state_reg.sv
module mc_state_reg
    import mc_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  state_e nxt,
    output state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= S_FETCH;
        end else begin
            cur <= nxt;
        end
    end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  state_e           cur,
    input  logic [OPC_W-1:0] opcode,
    output state_e           nxt
);
    op_class_e cls;

    always_comb begin
        cls = classify(opcode);
        nxt = S_FETCH;
        unique case (cur)
            S_FETCH:   nxt = S_DECODE;
            S_DECODE: begin
                unique case (cls)
                    CL_LOAD, CL_STORE: nxt = S_ADDR;
                    CL_RTYPE:          nxt = S_EXEC;
                    CL_BRANCH:         nxt = S_BRANCH;
                    CL_JUMP:           nxt = S_JUMP;
                    default:           nxt = S_FETCH;
                endcase
            end
            S_ADDR:    nxt = (cls == CL_STORE) ? S_STORE : S_LOAD_RD;
            S_LOAD_RD: nxt = S_LOAD_WB;
            S_EXEC:    nxt = S_RWB;
            default:   nxt = S_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
#(
    parameter logic [ALUOP_W-1:0] ADD_CODE = 3'b000,
    parameter logic [ALUOP_W-1:0] SUB_CODE = 3'b011
) (
    input  state_e             cur,
    input  logic [ALUOP_W-1:0] func,
    output ctrl_t              ctl
);
    always_comb begin
        ctl = CTRL_IDLE;
        unique case (cur)
            S_FETCH: begin
                ctl.pc_wr     = 1'b1;
                ctl.mem_rd    = 1'b1;
                ctl.ir_wr     = 1'b1;
                ctl.alu_src_b = SRCB_ONE;
                ctl.pc_src    = PCS_ALU;
                ctl.alu_op    = ADD_CODE;
            end
            S_DECODE: begin
                ctl.alu_src_b = SRCB_IMM;
                ctl.alu_op    = ADD_CODE;
            end
            S_ADDR: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_src_b = SRCB_IMM;
                ctl.alu_op    = ADD_CODE;
            end
            S_LOAD_RD: begin
                ctl.i_or_d = 1'b1;
                ctl.mem_rd = 1'b1;
            end
            S_LOAD_WB: begin
                ctl.reg_wr     = 1'b1;
                ctl.mem_to_reg = 1'b1;
            end
            S_STORE: begin
                ctl.i_or_d = 1'b1;
                ctl.mem_wr = 1'b1;
            end
            S_EXEC: begin
                ctl.alu_src_a = 1'b1;
                ctl.alu_src_b = SRCB_REG;
                ctl.alu_op    = func;
            end
            S_RWB: begin
                ctl.reg_dst = 1'b1;
                ctl.reg_wr  = 1'b1;
            end
            S_BRANCH: begin
                ctl.alu_src_a  = 1'b1;
                ctl.alu_src_b  = SRCB_REG;
                ctl.alu_op     = SUB_CODE;
                ctl.pc_wr_cond = 1'b1;
                ctl.pc_src     = PCS_OUT;
            end
            S_JUMP: begin
                ctl.pc_wr  = 1'b1;
                ctl.pc_src = PCS_JUMP;
            end
            default: ctl = CTRL_IDLE;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter logic [ALUOP_W-1:0] ADD_CODE = 3'b000,
    parameter logic [ALUOP_W-1:0] SUB_CODE = 3'b011
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OPC_W-1:0]   opcode,
    output logic               pc_wr,
    output logic               pc_wr_cond,
    output logic               i_or_d,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               mem_to_reg,
    output logic               ir_wr,
    output logic               reg_dst,
    output logic               reg_wr,
    output logic               alu_src_a,
    output logic [SEL_W-1:0]   alu_src_b,
    output logic [SEL_W-1:0]   pc_src,
    output logic [ALUOP_W-1:0] alu_op
);
    state_e cur;
    state_e nxt;
    ctrl_t  ctl;

    mc_state_reg u_sreg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt),
        .cur (cur)
    );

    mc_next_state u_nxt (
        .cur    (cur),
        .opcode (opcode),
        .nxt    (nxt)
    );

    mc_ctrl_decode #(
        .ADD_CODE (ADD_CODE),
        .SUB_CODE (SUB_CODE)
    ) u_dec (
        .cur  (cur),
        .func (opcode[ALUOP_W-1:0]),
        .ctl  (ctl)
    );

    assign pc_wr      = ctl.pc_wr;
    assign pc_wr_cond = ctl.pc_wr_cond;
    assign i_or_d     = ctl.i_or_d;
    assign mem_rd     = ctl.mem_rd;
    assign mem_wr     = ctl.mem_wr;
    assign mem_to_reg = ctl.mem_to_reg;
    assign ir_wr      = ctl.ir_wr;
    assign reg_dst    = ctl.reg_dst;
    assign reg_wr     = ctl.reg_wr;
    assign alu_src_a  = ctl.alu_src_a;
    assign alu_src_b  = ctl.alu_src_b;
    assign pc_src     = ctl.pc_src;
    assign alu_op     = ctl.alu_op;
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk
    import mc_ctrl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               pc_wr,
    input logic               pc_wr_cond,
    input logic               i_or_d,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic               mem_to_reg,
    input logic               ir_wr,
    input logic               reg_dst,
    input logic               reg_wr,
    input logic               alu_src_a,
    input logic [SEL_W-1:0]   alu_src_b,
    input logic [SEL_W-1:0]   pc_src
);
    // R2
    fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (!ir_wr && !alu_src_a && alu_src_b == SRCB_IMM));

    // R5
    load_read_to_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && i_or_d) |=> (reg_wr && mem_to_reg && !reg_dst));

    // R5
    writeback_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> ir_wr);

    // R6
    store_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_wr);

    // R7
    exec_to_rwb_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_src_a && alu_src_b == SRCB_REG && !pc_wr_cond)
            |=> (reg_wr && reg_dst && !mem_to_reg));

    // R8
    branch_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |=> ir_wr);

    // R9
    jump_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (pc_wr && pc_src == PCS_JUMP) |=> ir_wr);

    // R10
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R10
    pc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(pc_wr && pc_wr_cond));
endmodule

bind mc_ctrl_fsm mc_ctrl_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .i_or_d     (i_or_d),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .mem_to_reg (mem_to_reg),
    .ir_wr      (ir_wr),
    .reg_dst    (reg_dst),
    .reg_wr     (reg_wr),
    .alu_src_a  (alu_src_a),
    .alu_src_b  (alu_src_b),
    .pc_src     (pc_src)
);

// File: tb/test_mc_ctrl_fsm.sv
module test_mc_ctrl_fsm;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] opcode = 4'd0;
    logic       pc_wr, pc_wr_cond, i_or_d, mem_rd, mem_wr, mem_to_reg;
    logic       ir_wr, reg_dst, reg_wr, alu_src_a;
    logic [1:0] alu_src_b, pc_src;
    logic [2:0] alu_op;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mc_ctrl_fsm i_mc_ctrl_fsm (
        .clk (clk), .rst (rst), .opcode (opcode),
        .pc_wr (pc_wr), .pc_wr_cond (pc_wr_cond), .i_or_d (i_or_d),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .mem_to_reg (mem_to_reg),
        .ir_wr (ir_wr), .reg_dst (reg_dst), .reg_wr (reg_wr),
        .alu_src_a (alu_src_a), .alu_src_b (alu_src_b),
        .pc_src (pc_src), .alu_op (alu_op)
    );

    // Vector order: pc_wr pc_wr_cond i_or_d mem_rd mem_wr mem_to_reg ir_wr
    //               reg_dst reg_wr alu_src_a alu_src_b[1:0] pc_src[1:0] alu_op[2:0]
    function automatic logic [16:0] expect_vec(input int s, input logic [3:0] op);
        logic [16:0] v = '0;
        case (s)
            0: begin v[16] = 1; v[13] = 1; v[10] = 1; v[6:5] = 2'b01; end
            1: begin v[6:5] = 2'b10; end
            2: begin v[7] = 1; v[6:5] = 2'b10; end
            3: begin v[14] = 1; v[13] = 1; end
            4: begin v[8] = 1; v[11] = 1; end
            5: begin v[14] = 1; v[12] = 1; end
            6: begin v[7] = 1; v[2:0] = op[2:0]; end
            7: begin v[9] = 1; v[8] = 1; end
            8: begin v[7] = 1; v[2:0] = 3'b011; v[15] = 1; v[4:3] = 2'b01; end
            9: begin v[16] = 1; v[4:3] = 2'b10; end
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic [16:0] actual_vec();
        return {pc_wr, pc_wr_cond, i_or_d, mem_rd, mem_wr, mem_to_reg, ir_wr,
                reg_dst, reg_wr, alu_src_a, alu_src_b, pc_src, alu_op};
    endfunction

    // Called at a falling edge; compares every output against the step.
    task automatic check_step(input int s, input logic [3:0] op, input string req);
        logic [16:0] e = expect_vec(s, op);
        logic [16:0] a = actual_vec();
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s step %0d op %b: actual %b expected %b", req, s, op, a, e);
        end
    endtask

    // Runs one instruction from fetch along the expected step path.
    task automatic run_path(input logic [3:0] op, input int path[], input string req);
        opcode = op;
        foreach (path[i]) begin
            check_step(path[i], op, (i == 0) ? "R2" : req);
            @(negedge clk);
        end
        check_step(0, op, {req, " R10 back to fetch"});
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_step(0, 4'd0, "R1");
        rst = 1'b0;
    endtask

    task automatic t_load();
        run_path(4'b1000, '{0, 1, 2, 3, 4}, "R5 R4 R3");
    endtask

    task automatic t_store();
        run_path(4'b1001, '{0, 1, 2, 5}, "R6 R4");
    endtask

    task automatic t_rtype();
        for (int k = 0; k < 8; k++) begin
            run_path(k[3:0], '{0, 1, 6, 7}, "R7");
        end
    endtask

    task automatic t_branch();
        run_path(4'b1010, '{0, 1, 8}, "R8");
    endtask

    task automatic t_jump();
        run_path(4'b1011, '{0, 1, 9}, "R9");
    endtask

    task automatic t_bad();
        for (int k = 12; k < 16; k++) begin
            run_path(k[3:0], '{0, 1}, "R11");
        end
    endtask

    task automatic t_mid_reset();
        opcode = 4'b1000;
        check_step(0, opcode, "R2");
        repeat (3) @(negedge clk);
        check_step(3, opcode, "R5");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_step(0, opcode, "R1 mid-instruction");
        @(negedge clk);
        check_step(1, opcode, "R1 resume");
        opcode = 4'b1100;
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_load();
        t_store();
        t_rtype();
        t_branch();
        t_jump();
        t_bad();
        t_mid_reset();
        t_load();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule